// File: doc/BRIEF.md
# Error-Correcting Tag Store with Scrub and Replay

This block holds a small array of cache tags. Each tag is kept together with its own single-error-correct, double-error-detect check code, computed as the tag is written. A lookup names an entry and a tag to compare against. The block reads the stored code word, checks it, and answers hit or miss. When the check finds nothing wrong, the answer comes one cycle after the request is taken. No cycles are added for the checking.

When the stored word has exactly one flipped bit, the lookup is held. The block writes the repaired word back into the same entry and then replays the lookup on the clean word. Only the replayed answer is returned. When the word has two flipped bits, the entry cannot be repaired. The block reports the fault, drops the entry's valid flag and answers miss, so the requester refetches the line instead of taking a fault. Each corrected and each uncorrectable event produces a one-cycle pulse, together with the index of the entry involved.

A write port loads new tags. It also takes an XOR mask that is applied to the encoded word before storage, which lets a test place bit flips at chosen positions.

Top module: `tag_ecc_array`

## Requirements
- R1: Every tag is stored as a 40-bit word: the 33 tag bits, 6 Hamming check bits and 1 overall parity bit. The word is XORed with `wr_inject` as it is stored. Any single flipped bit, in any of the 40 positions, is corrected. Any two flipped bits, in any two positions, are detected as uncorrectable.
- R2: While `rst_n` is low (sampled on the clock), every entry becomes invalid. Out of reset, `req_ready` is 1 and `rsp_valid`, `err_corr` and `err_uncorr` are 0.
- R3: A lookup is taken on a clock edge where `req_valid` and `req_ready` are both 1. If the stored word is error-free, `rsp_valid` is 1 in the next cycle. In that cycle, `rsp_hit` is 1 exactly when the entry is valid and its stored tag equals the requested tag.
- R4: A lookup of an invalid entry answers miss after one cycle and raises no error pulse, whatever bits the entry holds.
- R5: On a single-bit error in a valid entry, `err_corr` pulses in the cycle after the lookup is taken, with `err_idx` set to the entry. No response is given in that cycle.
- R6: After a single-bit error, the repaired word is written back and the lookup is replayed. The response arrives three cycles after the lookup is taken and is judged on the repaired tag. A later lookup of the same entry is error-free.
- R7: On a double-bit error in a valid entry, three things happen in the cycle after the lookup is taken: `err_uncorr` pulses with `err_idx` set to the entry, and `rsp_valid` is 1 with `rsp_hit` 0. The entry is then invalid until it is written again.
- R8: `req_ready` is 0 from the cycle after a lookup is taken until its sequence has ended. While it is 0, a raised `req_valid` is not taken.
- R9: A replay that finds a clean word gives its response and returns to idle. It never starts a second repair.
- R10: If an external write targets the entry in the same cycle as the repair write, the external write is the one stored.
- R11: `err_corr` and `err_uncorr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a lookup this cycle |
| req_idx | input | IDX_W | Entry to look up |
| req_tag | input | TAG_W | Tag to compare against the entry |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Entry valid and tag matches |
| wr_en | input | 1 | Write a tag into an entry |
| wr_idx | input | IDX_W | Entry to write |
| wr_tag | input | TAG_W | Tag to store |
| wr_inject | input | CODE_W | XOR mask applied to the stored code word |
| err_corr | output | 1 | One-cycle pulse: single-bit error found and repaired |
| err_uncorr | output | 1 | One-cycle pulse: double-bit error, entry dropped |
| err_idx | output | IDX_W | Entry that the error pulse refers to |

## Verification
The bound checker watches a set of properties on every cycle. A clean lookup must answer or start a repair in the following cycle. A repair pulse must be followed by a stalled, silent cycle and then a replay answer. An uncorrectable pulse must come with a miss. The two error kinds must never coincide, and a clean replay must drop back to idle. Other behaviour can only be shown by the bench's scenarios: that every one of the 40 bit positions is corrected, that pairs of flips are caught, that the repaired word actually persists, that a dropped entry stays a miss, and that an external write wins over a repair to the same entry.

// File: rtl/tag_ecc_pkg.sv
// Shared types and constant functions for the error-protected tag store.
// Assumes data widths small enough that the check-bit count fits in an int.
package tag_ecc_pkg;

    // Lookup sequence: take request, check, optionally repair and replay.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FIX    = 2'd2,
        ST_RETRY  = 2'd3
    } seq_state_e;

    // Number of Hamming check bits needed to cover data_w data bits.
    function automatic int ham_checks(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < data_w + p + 1) begin
            p++;
        end
        return p;
    endfunction

endpackage

// File: rtl/tag_ecc_enc.sv
// Hamming SECDED encoder.
// Code word bit 0 is overall parity. Bits at power-of-two positions hold
// check bits. All other positions hold data bits in ascending order.
// Purely combinational.
module tag_ecc_enc
    import tag_ecc_pkg::*;
#(
    parameter  int DATA_W = 33,
    localparam int P      = ham_checks(DATA_W),
    localparam int CODE_W = DATA_W + P + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    localparam int TOP_POS = DATA_W + P;

    // Place data bits, then compute each check bit and the overall parity.
    always_comb begin
        int  d;
        logic par;
        code = '0;
        d    = 0;
        for (int pos = 1; pos <= TOP_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                code[pos] = data[d];
                d++;
            end
        end
        for (int b = 0; b < P; b++) begin
            par = 1'b0;
            for (int pos = 1; pos <= TOP_POS; pos++) begin
                if ((((pos >> b) & 1) != 0) && ((pos & (pos - 1)) != 0)) begin
                    par = par ^ code[pos];
                end
            end
            code[1 << b] = par;
        end
        code[0] = ^code[CODE_W-1:1];
    end

endmodule

// File: rtl/tag_ecc_dec.sv
// Hamming SECDED decoder matching tag_ecc_enc.
// Outputs a flag for a correctable or an uncorrectable error, the repaired
// code word (valid when the error is correctable) and the repaired data.
// Assumes the input word has at most two flipped bits when a result is trusted.
module tag_ecc_dec
    import tag_ecc_pkg::*;
#(
    parameter  int DATA_W = 33,
    localparam int P      = ham_checks(DATA_W),
    localparam int CODE_W = DATA_W + P + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] code_fix,
    output logic [DATA_W-1:0] data,
    output logic              err_single,
    output logic              err_double
);

    localparam int TOP_POS = DATA_W + P;

    // Syndrome and parity classify the error; a single flip is undone in place.
    always_comb begin
        logic [P-1:0] syn;
        logic         parity;
        int           d;
        syn = '0;
        for (int pos = 1; pos <= TOP_POS; pos++) begin
            if (code[pos]) begin
                syn = syn ^ P'(pos);
            end
        end
        parity     = ^code;
        code_fix   = code;
        err_single = 1'b0;
        err_double = 1'b0;
        if (parity) begin
            if (syn == '0) begin
                code_fix[0] = ~code[0];
                err_single  = 1'b1;
            end else if (int'(syn) <= TOP_POS) begin
                code_fix[syn] = ~code[syn];
                err_single    = 1'b1;
            end else begin
                err_double = 1'b1;
            end
        end else if (syn != '0) begin
            err_double = 1'b1;
        end
        data = '0;
        d    = 0;
        for (int pos = 1; pos <= TOP_POS; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data[d] = code_fix[pos];
                d++;
            end
        end
    end

endmodule

// File: rtl/tag_retry_fsm.sv
// Sequencer for one lookup: check, and on a correctable error repair and
// replay. Only a correctable error found while checking leads to a repair.
// Assumes err_single is already gated to the checking states.
module tag_retry_fsm
    import tag_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       err_single,
    output seq_state_e state
);

    seq_state_e nxt;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state choice for the check / repair / replay sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LOOKUP;
            ST_LOOKUP: nxt = err_single ? ST_FIX : ST_IDLE;
            ST_FIX:    nxt = ST_RETRY;
            ST_RETRY:  nxt = err_single ? ST_FIX : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/tag_ecc_array.sv
// Tag store with per-entry SECDED protection, repair-and-replay on a
// correctable error and entry invalidation on an uncorrectable one.
// One lookup is in flight at a time. The valid flags are not code-protected.
// The code words have no reset; an invalid entry is never checked.
module tag_ecc_array
    import tag_ecc_pkg::*;
#(
    parameter  int TAG_W  = 33,
    parameter  int IDX_W  = 4,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int CODE_W = TAG_W + ham_checks(TAG_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [CODE_W-1:0] wr_inject,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic [IDX_W-1:0]  err_idx
);

    logic [CODE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    seq_state_e        state;

    logic [CODE_W-1:0] wr_code;
    logic [CODE_W-1:0] rd_code;
    logic [CODE_W-1:0] fix_code;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic              dec_single;
    logic              dec_double;
    logic              checking;
    logic              hit_single;
    logic              hit_double;
    logic              accept;
    logic              fix_we;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    tag_ecc_enc #(.DATA_W(TAG_W)) u_enc (
        .data (wr_tag),
        .code (wr_code)
    );

    assign rd_code  = mem[idx_q];
    assign rd_valid = valid_q[idx_q];

    tag_ecc_dec #(.DATA_W(TAG_W)) u_dec (
        .code       (rd_code),
        .code_fix   (fix_code),
        .data       (rd_tag),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    assign checking   = (state == ST_LOOKUP) || (state == ST_RETRY);
    assign hit_single = checking && rd_valid && dec_single;
    assign hit_double = checking && rd_valid && dec_double;

    tag_retry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .err_single (hit_single),
        .state      (state)
    );

    // Capture the lookup operands when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tag_q <= '0;
        end else if (accept) begin
            idx_q <= req_idx;
            tag_q <= req_tag;
        end
    end

    // Valid flags: set by a write, cleared by an uncorrectable check.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
            end else if (hit_double && (idx_q == IDX_W'(i))) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    // A repair write yields to an external write aimed at the same entry.
    assign fix_we = (state == ST_FIX) && !(wr_en && (wr_idx == idx_q));

    // Code-word storage: external writes and repair write-backs.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_code ^ wr_inject;
        if (fix_we) mem[idx_q] <= fix_code;
    end

    // Response and error reporting, driven from the checking states.
    assign rsp_valid  = checking && !hit_single;
    assign rsp_hit    = rsp_valid && rd_valid && !dec_double && (rd_tag == tag_q);
    assign err_corr   = hit_single;
    assign err_uncorr = hit_double;
    assign err_idx    = idx_q;

endmodule

// File: rtl/tag_ecc_array_chk.sv
// Cycle-level protocol checker for tag_ecc_array, attached with bind.
// Watches the lookup handshake, the error pulses and the sequencer state.
module tag_ecc_array_chk
    import tag_ecc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       err_corr,
    input logic       err_uncorr,
    input seq_state_e state
);

    AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr)); // R11

    AST_CLEAN_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || err_corr)); // R3

    AST_FIX_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |=> (!rsp_valid && !req_ready)); // R5

    AST_REPLAY_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |=> ##1 (rsp_valid || err_corr)); // R6

    AST_UNCORR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        err_uncorr |-> (rsp_valid && !rsp_hit)); // R7

    AST_BUSY_WHILE_ANSWERING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R8

    AST_CLEAN_REPLAY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETRY && !err_corr) |=> (state == ST_IDLE)); // R9

endmodule

bind tag_ecc_array tag_ecc_array_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .state      (state)
);

// File: tb/tag_ecc_array_test.sv
// Scoreboard bench: driver tasks push expected answers, a monitor pops and
// compares them as responses appear.
module tag_ecc_array_test;

    localparam int TAG_W  = 33;
    localparam int IDX_W  = 4;
    localparam int DEPTH  = 16;
    localparam int CODE_W = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [TAG_W-1:0]  wr_tag = '0;
    logic [CODE_W-1:0] wr_inject = '0;
    logic              err_corr;
    logic              err_uncorr;
    logic [IDX_W-1:0]  err_idx;

    always #5 clk = ~clk;

    tag_ecc_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_idx    (req_idx),
        .req_tag    (req_tag),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_inject  (wr_inject),
        .err_corr   (err_corr),
        .err_uncorr (err_uncorr),
        .err_idx    (err_idx)
    );

    typedef struct {
        logic             hit;
        int               corr;
        int               unc;
        int               cyc;
        logic [IDX_W-1:0] idx;
        string            rq;
    } exp_t;

    exp_t             sb[$];
    int               cyc = 0;
    int               n_vec = 0;
    int               n_bad = 0;
    int               n_corr = 0;
    int               n_unc = 0;
    logic [IDX_W-1:0] seen_idx = '0;
    bit               ref_valid [DEPTH];
    logic [TAG_W-1:0] ref_tag   [DEPTH];
    int               ref_flips [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: collect error pulses and compare each response with the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (err_corr) begin
                n_corr++;
                seen_idx = err_idx;
            end
            if (err_uncorr) begin
                n_unc++;
                seen_idx = err_idx;
            end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3", "unexpected response", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(rsp_hit === e.hit, e.rq, "hit", rsp_hit, e.hit);
                    check(cyc == e.cyc, e.rq, "response cycle", cyc, e.cyc);
                    check(n_corr == e.corr, e.rq, "corrected pulses", n_corr, e.corr);
                    check(n_unc == e.unc, e.rq, "uncorrectable pulses", n_unc, e.unc);
                    if (e.corr != 0 || e.unc != 0)
                        check(seen_idx == e.idx, e.rq, "error index", seen_idx, e.idx);
                end
                n_corr = 0;
                n_unc  = 0;
            end
        end
    end

    task automatic write(input int idx, input logic [TAG_W-1:0] tag,
                         input logic [CODE_W-1:0] mask);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_idx    = IDX_W'(idx);
        wr_tag    = tag;
        wr_inject = mask;
        @(negedge clk);
        wr_en     = 1'b0;
        wr_inject = '0;
        ref_valid[idx] = 1'b1;
        ref_tag[idx]   = tag;
        ref_flips[idx] = $countones(mask);
    endtask

    // Build the expected answer from the reference model and update it.
    function automatic exp_t predict(input int idx, input logic [TAG_W-1:0] tag,
                                     input string rq, input int now);
        exp_t e;
        e.idx  = IDX_W'(idx);
        e.rq   = rq;
        e.corr = 0;
        e.unc  = 0;
        e.cyc  = now + 1;
        e.hit  = 1'b0;
        if (ref_valid[idx]) begin
            if (ref_flips[idx] == 0) begin
                e.hit = (ref_tag[idx] == tag);
            end else if (ref_flips[idx] == 1) begin
                e.corr = 1;
                e.cyc  = now + 3;
                e.hit  = (ref_tag[idx] == tag);
                ref_flips[idx] = 0;
            end else begin
                e.unc = 1;
                ref_valid[idx] = 1'b0;
            end
        end
        return e;
    endfunction

    task automatic lookup(input int idx, input logic [TAG_W-1:0] tag, input string rq);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_idx   = IDX_W'(idx);
        req_tag   = tag;
        sb.push_back(predict(idx, tag, rq, cyc));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_valid[i] = 1'b0;
            ref_tag[i]   = '0;
            ref_flips[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle outputs after reset
        check(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R2", "rsp_valid after reset", rsp_valid, 0);
        check(err_corr == 1'b0 && err_uncorr == 1'b0, "R2", "error pulses after reset",
              {err_corr, err_uncorr}, 0);

        // R4: every entry starts invalid
        for (int i = 0; i < DEPTH; i++) lookup(i, '0, "R4");

        // R3: clean hits and misses with several tag patterns
        write(3, 33'h1_2345_6789, '0);
        write(4, '1, '0);
        write(5, 33'h0_0000_0001, '0);
        lookup(3, 33'h1_2345_6789, "R3");
        lookup(3, 33'h1_2345_6788, "R3");
        lookup(4, '1, "R3");
        lookup(5, 33'h1_0000_0001, "R3");
        lookup(5, 33'h0_0000_0001, "R3");

        // R1, R5, R6: every single flip is repaired, replay hits, then clean
        for (int p = 0; p < CODE_W; p++) begin
            write(7, 33'h0_A5A5_5A5A ^ TAG_W'(p), CODE_W'(1) << p);
            lookup(7, 33'h0_A5A5_5A5A ^ TAG_W'(p), "R6");
            lookup(7, 33'h0_A5A5_5A5A ^ TAG_W'(p), "R6");
        end
        // R5: single flip with a mismatching tag still repairs, answers miss
        write(8, 33'h0_DEAD_BEEF, CODE_W'(1) << 12);
        lookup(8, 33'h0_DEAD_BEE0, "R5");
        lookup(8, 33'h0_DEAD_BEEF, "R5");

        // R1, R7, R4: double flips drop the entry; later lookups miss silently
        for (int p = 0; p < CODE_W; p += 3) begin
            write(10, 33'h1_0F0F_F0F0, (CODE_W'(1) << p) | (CODE_W'(1) << ((p + 13) % CODE_W)));
            lookup(10, 33'h1_0F0F_F0F0, "R7");
            lookup(10, 33'h1_0F0F_F0F0, "R4");
        end
        write(10, 33'h1_0F0F_F0F0, '0);
        lookup(10, 33'h1_0F0F_F0F0, "R7");

        // R8, R9: stall while repairing; a held request waits for idle
        write(9, 33'h0_1357_9BDF, CODE_W'(1) << 20);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 4'd9;
        req_tag   = 33'h0_1357_9BDF;
        sb.push_back(predict(9, 33'h0_1357_9BDF, "R9", cyc));
        @(negedge clk);
        req_idx = 4'd3;
        req_tag = 33'h1_2345_6789;
        check(req_ready == 1'b0, "R8", "ready while checking", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b0, "R8", "ready while repairing", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b0, "R8", "ready while replaying", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready after clean replay", req_ready, 1);
        sb.push_back(predict(3, 33'h1_2345_6789, "R8", cyc));
        @(negedge clk);
        req_valid = 1'b0;

        // R10: external write in the repair cycle overrides the repair
        write(6, 33'h0_CAFE_0000, CODE_W'(1) << 30);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 4'd6;
        req_tag   = 33'h1_BEEF_1111;
        sb.push_back(predict(6, 33'h0_CAFE_0000, "R10", cyc));
        sb[sb.size()-1].hit = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        wr_en     = 1'b1;
        wr_idx    = 4'd6;
        wr_tag    = 33'h1_BEEF_1111;
        wr_inject = '0;
        @(negedge clk);
        wr_en = 1'b0;
        ref_valid[6] = 1'b1;
        ref_tag[6]   = 33'h1_BEEF_1111;
        ref_flips[6] = 0;
        lookup(6, 33'h1_BEEF_1111, "R10");
        lookup(6, 33'h0_CAFE_0000, "R10");

        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R3", "outstanding responses", sb.size(), 0);
        finish_run();
    end

endmodule